// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This block is an SPI master that hangs off a 32-bit register bus. It has two word registers. The first holds the configuration (clock divider, loopback enable, three chip-select levels) and also takes the start command and reports whether a transfer is in flight. The second takes the byte to send and returns the byte received. Software loads the transmit byte, writes the configuration word with the start bit set, polls until busy drops and then reads the received byte. Each start command moves exactly one byte in each direction.

The serial clock is derived from the reference clock by a programmable divider. Each SCK half period lasts d+1 reference cycles, so the SCK frequency is f_ref / (2(d+1)). With the usual 50 MHz reference, d = 0 gives 25 MHz. The bus uses SPI mode 0, sends MSB first, and keeps SCK low when idle. In loopback mode the byte shifted out is fed back into the receive path in place of the MISO pin.

Top module: `spim_top`

## Requirements
- R1: After synchronous reset the control word reads 0x00000015: all three chip selects high, divider 0, loopback off, busy 0. SCK and MOSI are low.
- R2: A control write (byte address 0x0) with bit 1 set while idle starts a transfer. Control bit 1 reads 1 from the next cycle on, for exactly 16(d+1) cycles, and then reads 0.
- R3: Chip-select output n equals control bit 2n (bits 0, 2 and 4), with no inversion.
- R4: When control bit 3 is 1, the received byte equals the transmitted byte and MISO is ignored.
- R5: SCK is low while idle. During a transfer it toggles every d+1 reference cycles, where d is control bits 31:27, which gives 8 rising edges 2(d+1) cycles apart.
- R6: Data is sent MSB first in mode 0. MOSI shows bit 7 from the start and changes only when SCK falls. MISO is sampled when SCK rises, and the first bit sampled becomes bit 7 of the received byte.
- R7: A write to the data register (byte address 0x4) keeps only bits 7:0 as the transmit byte. A data read returns the received byte in bits 7:0, with bits 31:8 zero.
- R8: While busy, writes to either register are ignored. The transmit byte, divider, loopback and chip selects stay unchanged, and a second start does not extend the transfer.
- R9: A control write without bit 1 while idle takes effect on the next cycle. A control read returns divider, loopback and chip selects as written, bits 26:5 zero, and the live busy flag in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Byte address, bit 2 selects the data register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select levels, index n driven by control bit 2n |

## Verification
A configuration write shows on the outputs and in the read data one cycle after the write edge. Busy is set on the first cycle after a start. The first SCK rise comes d+1 cycles after the start, and busy and the final SCK fall arrive together 16(d+1) cycles after it. The bench model advances on the same clock edge as the design, and every output and the read data are compared a quarter period after each rising edge, so every result is checked in the cycle it becomes due. Directed checks also count busy cycles, measure the SCK period, and read the received byte once busy drops.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int BUS_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int DIV_W     = 5;
    localparam int NCS       = 3;
    localparam int START_BIT = 1;
    localparam int LOOP_BIT  = 3;
    localparam int DIV_LSB   = BUS_W - DIV_W;
    localparam int EDGES     = 2 * BYTE_W;
    localparam int EDGE_W    = $clog2(EDGES) + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             loop;
        logic [NCS-1:0]   cs;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{div: '0, loop: 1'b0, cs: '1};

    function automatic cfg_t unpack_cfg(input logic [BUS_W-1:0] w);
        cfg_t c;
        c.div  = w[DIV_LSB +: DIV_W];
        c.loop = w[LOOP_BIT];
        for (int i = 0; i < NCS; i++) c.cs[i] = w[2*i];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(input cfg_t c, input logic busy);
        logic [BUS_W-1:0] w;
        w = '0;
        w[DIV_LSB +: DIV_W] = c.div;
        w[LOOP_BIT]         = c.loop;
        w[START_BIT]        = busy;
        for (int i = 0; i < NCS; i++) w[2*i] = c.cs[i];
        return w;
    endfunction
endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             sel_data,
    input  logic [BUS_W-1:0] wdata,
    input  logic             busy,
    output cfg_t             cfg,
    output logic [BYTE_W-1:0] tx,
    output logic             start
);
    logic accept;
    assign accept = wr && !busy;
    assign start  = accept && !sel_data && wdata[START_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
            tx  <= '0;
        end else if (accept) begin
            if (sel_data) tx  <= wdata[BYTE_W-1:0];
            else          cfg <= unpack_cfg(wdata);
        end
    end

    // R8: configuration frozen for the whole transfer
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(cfg) && $stable(tx)));
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    // R5: half-period counter never passes the divider value
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= div);
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  logic [BYTE_W-1:0] tx,
    input  logic              loop,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx
);
    logic [BYTE_W-1:0] sh;
    logic [EDGE_W-1:0] edges;
    logic              in_bit;

    assign mosi   = sh[BYTE_W-1];
    assign in_bit = loop ? sh[BYTE_W-1] : miso;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            sck   <= 1'b0;
            sh    <= '0;
            rx    <= '0;
            edges <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            sck   <= 1'b0;
            sh    <= tx;
            edges <= '0;
        end else if (busy && tick) begin
            sck   <= ~sck;
            edges <= edges + 1'b1;
            if (!sck) rx <= {rx[BYTE_W-2:0], in_bit};
            else      sh <= {sh[BYTE_W-2:0], 1'b0};
            if (edges == EDGE_W'(EDGES - 1)) busy <= 1'b0;
        end
    end

    // R5: SCK idles low
    a_r5_sck_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);
    // R6: MOSI moves only on a falling SCK edge
    a_r6_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi));
    // R2: an accepted start raises busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic [NCS-1:0]   spi_cs
);
    cfg_t              cfg;
    logic [BYTE_W-1:0] tx, rx;
    logic              start, busy, tick, sel_data;
    logic              unused_addr;

    assign sel_data    = bus_addr[2];
    assign unused_addr = ^bus_addr[1:0];

    spim_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .sel_data(sel_data),
        .wdata(bus_wdata), .busy(busy), .cfg(cfg), .tx(tx), .start(start)
    );

    spim_clkdiv u_div (
        .clk(clk), .rst(rst), .run(busy), .div(cfg.div), .tick(tick)
    );

    spim_shift u_shift (
        .clk(clk), .rst(rst), .start(start), .tick(tick), .tx(tx),
        .loop(cfg.loop), .miso(spi_miso), .busy(busy), .sck(spi_sck),
        .mosi(spi_mosi), .rx(rx)
    );

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign spi_cs[i] = cfg.cs[i];
    end

    assign bus_rdata = sel_data ? {{(BUS_W-BYTE_W){1'b0}}, rx}
                                : pack_status(cfg, busy);

    // R7: data reads keep the upper bits clear
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        sel_data |-> (bus_rdata[BUS_W-1:BYTE_W] == '0));
endmodule

// File: tb/sim_spim_top.sv
module sim_spim_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_wr = 1'b0;
    logic [2:0]  b_addr = 3'd0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        sck, mosi, miso;
    logic [2:0]  cs;

    int errors = 0, checks = 0;
    longint cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spim_top u0 (
        .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs)
    );

    // external slave on chip select 0, mode 0
    logic [7:0] slv_byte = 8'h00, slv_sh = 8'h00, slv_rx = 8'h00;
    assign miso = cs[0] ? 1'b0 : slv_sh[7];
    always @(posedge sck) if (!cs[0]) slv_rx = {slv_rx[6:0], mosi};
    always @(negedge sck) if (!cs[0]) slv_sh = {slv_sh[6:0], 1'b0};

    // SCK period measurement in reference cycles
    longint last_rise = -1;
    longint last_per = 0;
    always @(posedge clk) cyc++;
    always @(posedge sck) begin
        if (last_rise >= 0) last_per = cyc - last_rise;
        last_rise = cyc;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    int m_div = 0, m_cnt = 0, m_edges = 0;
    bit m_loop = 0, m_busy = 0, m_sck = 0;
    bit [2:0] m_cs = 3'b111;
    bit [7:0] m_tx = 0, m_sh = 0, m_rx = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_cnt = 0; m_edges = 0; m_loop = 0; m_busy = 0;
            m_sck = 0; m_cs = 3'b111; m_tx = 0; m_sh = 0; m_rx = 0;
        end else if (m_busy) begin
            m_cnt++;
            if (m_cnt == m_div + 1) begin
                m_cnt = 0;
                if (!m_sck) begin
                    bit b;
                    b = m_loop ? m_sh[7] : (m_cs[0] ? 1'b0 : slv_byte[7 - m_edges/2]);
                    m_rx = {m_rx[6:0], b};
                end else begin
                    m_sh = m_sh << 1;
                end
                m_sck = !m_sck;
                m_edges++;
                if (m_edges == 16) m_busy = 0;
            end
        end else if (b_wr) begin
            if (b_addr[2]) m_tx = b_wdata[7:0];
            else begin
                m_div  = int'(b_wdata[31:27]);
                m_loop = b_wdata[3];
                m_cs   = {b_wdata[4], b_wdata[2], b_wdata[0]};
                if (b_wdata[1]) begin
                    m_busy = 1; m_cnt = 0; m_edges = 0; m_sck = 0; m_sh = m_tx;
                end
            end
        end
    end

    function automatic logic [31:0] m_ctrl();
        logic [31:0] w;
        w = '0;
        w[31:27] = 5'(m_div);
        w[4] = m_cs[2]; w[3] = m_loop; w[2] = m_cs[1]; w[1] = m_busy; w[0] = m_cs[0];
        return w;
    endfunction

    // per-cycle comparison a quarter period after each rising edge
    initial forever begin
        @(posedge clk);
        #5;
        if (!rst && !finished) begin
            check(sck == m_sck, "R5 sck", sck, m_sck);
            check(mosi == m_sh[7], "R6 mosi", mosi, m_sh[7]);
            check(cs == m_cs, "R3 cs", cs, m_cs);
            if (b_addr[2]) check(rdata == {24'd0, m_rx}, "R7 data read", rdata, {24'd0, m_rx});
            else           check(rdata == m_ctrl(), "R9 ctrl read", rdata, m_ctrl());
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        b_wr = 1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_wr = 0; b_addr = 3'd0;
    endtask

    function automatic logic [31:0] ctrl_word(input int d, input bit lp, input bit [2:0] c, input bit go);
        return {5'(d), 22'd0, c[2], lp, c[1], go, c[0]};
    endfunction

    // wait while busy, return number of busy cycles seen (ends at a negedge)
    task automatic wait_idle(output int n);
        n = 0;
        b_addr = 3'd0;
        #1;
        while (rdata[1]) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic xfer(input int d, input bit lp, input bit [2:0] c,
                        input logic [31:0] txw, input logic [7:0] sb, input logic [7:0] exp_rx);
        int n;
        slv_byte = sb; slv_sh = sb; slv_rx = 8'h00;
        bus_write(3'd4, txw);
        last_rise = -1; last_per = 0;
        bus_write(3'd0, ctrl_word(d, lp, c, 1'b1));
        wait_idle(n);
        check(n == 16 * (d + 1), "R2 busy length", n, 16 * (d + 1));
        check(last_per == 2 * (d + 1), "R5 sck period", last_per, 2 * (d + 1));
        b_addr = 3'd4; #1;
        check(rdata == {24'd0, exp_rx}, "R7 rx byte", rdata, {24'd0, exp_rx});
        if (!c[0]) check(slv_rx == txw[7:0], "R6 slave received", slv_rx, txw[7:0]);
        @(negedge clk); b_addr = 3'd0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check(rdata == 32'h15, "R1 reset ctrl", rdata, 32'h15);
        check(cs == 3'b111 && sck == 0 && mosi == 0, "R1 reset pins", {cs, sck, mosi}, 5'b11100);

        // R9 / R3 configuration without start applies next cycle
        bus_write(3'd0, ctrl_word(3, 0, 3'b110, 0));
        #1;
        check(rdata == 32'h18000014, "R9 cfg readback", rdata, 32'h18000014);
        check(cs == 3'b110, "R3 cs levels", cs, 3'b110);
        check(sck == 0, "R5 sck idle", sck, 0);

        // R4 loopback, fastest divider
        xfer(0, 1, 3'b111, 32'h000000A5, 8'h00, 8'hA5);
        // R6 external slave exchange, MSB first
        xfer(2, 0, 3'b110, 32'h0000003C, 8'hC3, 8'hC3);
        xfer(5, 0, 3'b110, 32'h00000081, 8'h7E, 8'h7E);
        // R4 loopback ignores MISO from an active slave
        xfer(1, 1, 3'b110, 32'h00000096, 8'hFF, 8'h96);
        // R5 largest divider
        xfer(31, 1, 3'b111, 32'h0000005A, 8'h00, 8'h5A);
        // R7 upper data bits dropped
        xfer(0, 1, 3'b011, 32'hFFFFFF12, 8'h00, 8'h12);

        // R8 writes while busy are ignored
        bus_write(3'd4, 32'h00000011);
        bus_write(3'd0, ctrl_word(3, 1, 3'b101, 1));
        bus_write(3'd4, 32'h000000EE);
        bus_write(3'd0, ctrl_word(0, 0, 3'b000, 1));
        #1;
        check(cs == 3'b101, "R8 cs held while busy", cs, 3'b101);
        wait_idle(n);
        check(n == 64 - 4, "R8 busy not extended", n, 60);
        check(rdata == ctrl_word(3, 1, 3'b101, 0), "R8 cfg unchanged", rdata, ctrl_word(3, 1, 3'b101, 0));
        b_addr = 3'd4; #1;
        check(rdata == 32'h11, "R8 rx from original tx", rdata, 32'h11);
        @(negedge clk);
        // R8 transmit byte not overwritten: resend without new data write
        bus_write(3'd0, ctrl_word(0, 1, 3'b111, 1));
        wait_idle(n);
        b_addr = 3'd4; #1;
        check(rdata == 32'h11, "R8 tx byte kept", rdata, 32'h11);
        @(negedge clk); b_addr = 3'd0;
        repeat (4) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule